// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block follows a processor core through its clock-stopping power states. It runs from an always-on reference clock and takes event inputs from the core and the platform: a halt indication, a stop-clock request, a sleep request, a bus snoop request, four interrupt lines, a flush request and a core reset. From these it keeps one of six states and drives the clock enables for the core and the cache, a snoop acknowledge, a flush acknowledge, the vector of interrupts held while the core clock was off, and a one-cycle protocol-error flag.

The platform bus clock arrives as a plain input sampled on the reference clock. A watchdog counter marks the bus clock as lost when no edge of it is seen for `LOSS_CYC` reference cycles. Leaving the deepest state waits for a settle interval of `SETTLE_CYC` reference cycles after the bus clock returns. This stands in for the time the clock multiplier needs to relock. Interrupt edges that arrive while the core clock is stopped are stored once each and handed over when the core runs again.

State codes seen on `stateCode`: 1 Normal, 2 AutoHALT, 3 Stop-Grant, 4 Halt/Grant-Snoop, 5 Sleep, 6 Deep Sleep. Bit positions of the interrupt vector: [3] SMI, [2] INIT, [1] NMI, [0] INTR.

Top module: `pwr_state_ctl`

## Requirements
- R1: After block reset the state is Normal (code 1). Both clock enables are 1. `snoopAck`, `flushAck`, `protoErr` and `pendIrq` are 0.
- R2: `haltEvt` in Normal moves to AutoHALT (code 2) at the next edge. A rising edge on any interrupt line in AutoHALT, or a held interrupt in `pendIrq`, moves back to Normal at the next edge.
- R3: `flushReq` in AutoHALT gives a one-cycle `flushAck` pulse and the state stays AutoHALT. `flushReq` in Stop-Grant gives no pulse and does not change the state.
- R4: `stopClkReq` in Normal or AutoHALT moves to Stop-Grant (code 3) at the next edge. Dropping it in Stop-Grant returns to the state that Stop-Grant was entered from.
- R5: In Stop-Grant a rising edge on an interrupt line sets its bit in `pendIrq` ([3] SMI, [2] INIT, [1] NMI, [0] INTR), and the state does not change. Repeated edges hold a single bit. The bits stay set until the first edge after the state reads Normal, at which point they clear.
- R6: `snoopReq` in AutoHALT or Stop-Grant moves to Halt/Grant-Snoop (code 4) with `snoopAck` = 1. When `snoopReq` drops, the state returns to the state the snoop came from.
- R7: `sleepReq` moves Stop-Grant to Sleep (code 5) only after it has been held across two rising bus-clock edges. In Normal and AutoHALT it has no effect.
- R8: In Sleep, a bus clock with no edge for `LOSS_CYC` reference cycles moves to Deep Sleep (code 6). Once edges return, Deep Sleep stays until `SETTLE_CYC` reference cycles have passed and then moves to Sleep. Dropping `sleepReq` in Sleep returns to Stop-Grant.
- R9: `cpuReset` in Stop-Grant keeps the state at Stop-Grant, clears `pendIrq` and makes Normal the return target. `cpuReset` in Sleep moves straight to Normal.
- R10: `coreClkEn` is 0 in Stop-Grant, Sleep and Deep Sleep and 1 in every other state. `cacheClkEn` is 0 only in Deep Sleep.
- R11: A change on `snoopReq` or on any interrupt line while in Sleep or Deep Sleep raises `protoErr` for one cycle, and the state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rstN | input | 1 | Active-low synchronous block reset |
| busClkIn | input | 1 | Platform bus clock, sampled as data |
| haltEvt | input | 1 | Core executed a halt |
| stopClkReq | input | 1 | Stop-clock request level |
| sleepReq | input | 1 | Sleep request level |
| snoopReq | input | 1 | Bus snoop pending level |
| smiIn | input | 1 | System-management interrupt line |
| initIn | input | 1 | Init interrupt line |
| nmiIn | input | 1 | Non-maskable interrupt line |
| intrIn | input | 1 | Maskable interrupt line |
| flushReq | input | 1 | Cache flush request |
| cpuReset | input | 1 | Core reset request |
| stateCode | output | 3 | Current state code 1 to 6 |
| coreClkEn | output | 1 | Core clock enable |
| cacheClkEn | output | 1 | Cache clock enable |
| snoopAck | output | 1 | Snoop being serviced |
| flushAck | output | 1 | One-cycle flush service pulse |
| pendIrq | output | 4 | Interrupts held while clock stopped |
| protoErr | output | 1 | One-cycle protocol violation flag |

## Verification
A wrong state register shows on `stateCode` and on the clock enables one reference cycle after the event that caused it. The exception is Sleep and Deep Sleep entry and exit, which depend on the bus-clock counters and are checked once those windows close. A wrong return target first shows on the cycle after a snoop or stop-clock release, when the machine goes to the wrong state. A latch fault shows on `pendIrq` one cycle after the interrupt edge, or as a vector that does not clear one cycle after Normal is reached. Counter faults show as Deep Sleep being entered or left early or late against the bus-clock stop and restart.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL    = 3'd1,
    ST_AUTOHALT  = 3'd2,
    ST_STOPGRANT = 3'd3,
    ST_SNOOP     = 3'd4,
    ST_SLEEP     = 3'd5,
    ST_DEEP      = 3'd6
  } pwrState_e;

  // control -> datapath
  typedef struct packed {
    logic latchEn;   // hold interrupt edges
    logic clrPend;   // drop held interrupts
    logic sleepy;    // Sleep or Deep Sleep
    logic inDeep;    // Deep Sleep
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic irqEdge;
    logic pendAny;
    logic sleepOk;
    logic busLost;
    logic settleDone;
  } dpStatus_t;

  localparam int IRQ_W = 4;

endpackage

// File: rtl/pwr_dp.sv
module pwr_dp
  import pwr_pkg::*;
#(
  parameter int LOSS_CYC    = 16,
  parameter int SETTLE_CYC  = 100000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busClkIn,
  input  logic [IRQ_W-1:0] irqIn,
  input  logic             snoopReq,
  input  logic             sleepReq,
  input  ctrlStrobe_t      strobe,
  output dpStatus_t        status,
  output logic [IRQ_W-1:0] pendIrq,
  output logic             protoErr
);

  localparam int LOSS_W   = $clog2(LOSS_CYC + 1);
  localparam int SETTLE_W = $clog2(SETTLE_CYC + 1);

  // bus clock synchroniser plus one history stage
  logic [SYNC_STAGES:0] busSync;
  logic busEdge, busRise;
  always_ff @(posedge clk) begin
    if (!rstN) busSync <= '0;
    else       busSync <= {busSync[SYNC_STAGES-1:0], busClkIn};
  end
  assign busEdge = busSync[SYNC_STAGES] ^ busSync[SYNC_STAGES-1];
  assign busRise = busSync[SYNC_STAGES-1] & ~busSync[SYNC_STAGES];

  // bus clock loss watchdog
  logic [LOSS_W-1:0] lossCnt;
  logic busLost;
  always_ff @(posedge clk) begin
    if (!rstN || busEdge) begin
      lossCnt <= '0;
      busLost <= 1'b0;
    end else if (lossCnt == LOSS_W'(LOSS_CYC)) begin
      busLost <= 1'b1;
    end else begin
      lossCnt <= lossCnt + LOSS_W'(1);
    end
  end

  // sleep request qualification: two rising bus edges while held
  logic [1:0] riseCnt;
  always_ff @(posedge clk) begin
    if (!rstN || !sleepReq)            riseCnt <= 2'd0;
    else if (busRise && riseCnt != 2'd2) riseCnt <= riseCnt + 2'd1;
  end

  // settle timer for leaving Deep Sleep
  logic [SETTLE_W-1:0] settleCnt;
  logic settleDone;
  assign settleDone = (settleCnt == SETTLE_W'(SETTLE_CYC));
  always_ff @(posedge clk) begin
    if (!rstN || !strobe.inDeep || busLost) settleCnt <= '0;
    else if (!settleDone)                   settleCnt <= settleCnt + SETTLE_W'(1);
  end

  // interrupt edge detection, latching and protocol check
  logic [IRQ_W-1:0] irqPrev, irqRise;
  logic snoopPrev;
  assign irqRise = irqIn & ~irqPrev;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPrev   <= '0;
      snoopPrev <= 1'b0;
      pendIrq   <= '0;
      protoErr  <= 1'b0;
    end else begin
      irqPrev   <= irqIn;
      snoopPrev <= snoopReq;
      if (strobe.clrPend)      pendIrq <= '0;
      else if (strobe.latchEn) pendIrq <= pendIrq | irqRise;
      protoErr <= strobe.sleepy && ((irqIn != irqPrev) || (snoopReq != snoopPrev));
    end
  end

  assign status.irqEdge    = |irqRise;
  assign status.pendAny    = |pendIrq;
  assign status.sleepOk    = (riseCnt == 2'd2);
  assign status.busLost    = busLost;
  assign status.settleDone = settleDone;

  // R5: held bits only appear while latching is enabled
  a_r5_latch_window: assert property (@(posedge clk) disable iff (!rstN)
    (|(pendIrq & ~$past(pendIrq))) |-> $past(strobe.latchEn));

  // R11: error flag only follows a cycle in Sleep or Deep Sleep
  a_r11_err_sleepy: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> $past(strobe.sleepy));

endmodule

// File: rtl/pwr_ctrl.sv
module pwr_ctrl
  import pwr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        haltEvt,
  input  logic        stopClkReq,
  input  logic        sleepReq,
  input  logic        snoopReq,
  input  logic        flushReq,
  input  logic        cpuReset,
  input  dpStatus_t   status,
  output pwrState_e   state,
  output ctrlStrobe_t strobe,
  output logic        flushAck,
  output logic        coreClkEn,
  output logic        cacheClkEn,
  output logic        snoopAck
);

  pwrState_e nextState, origin, originNext, snoopRet, snoopRetNext;
  logic flushNext;

  always_comb begin
    nextState    = state;
    originNext   = origin;
    snoopRetNext = snoopRet;
    flushNext    = 1'b0;
    unique case (state)
      ST_NORMAL: begin
        if (cpuReset)        nextState = ST_NORMAL;
        else if (stopClkReq) begin nextState = ST_STOPGRANT; originNext = ST_NORMAL; end
        else if (haltEvt)    nextState = ST_AUTOHALT;
      end
      ST_AUTOHALT: begin
        if (cpuReset)        nextState = ST_NORMAL;
        else if (stopClkReq) begin nextState = ST_STOPGRANT; originNext = ST_AUTOHALT; end
        else if (snoopReq)   begin nextState = ST_SNOOP; snoopRetNext = ST_AUTOHALT; end
        else if (status.irqEdge || status.pendAny) nextState = ST_NORMAL;
        else if (flushReq)   flushNext = 1'b1;
      end
      ST_STOPGRANT: begin
        if (cpuReset)        originNext = ST_NORMAL;
        else if (snoopReq)   begin nextState = ST_SNOOP; snoopRetNext = ST_STOPGRANT; end
        else if (!stopClkReq) nextState = origin;
        else if (sleepReq && status.sleepOk) nextState = ST_SLEEP;
      end
      ST_SNOOP: begin
        if (!snoopReq) nextState = snoopRet;
      end
      ST_SLEEP: begin
        if (cpuReset)            nextState = ST_NORMAL;
        else if (status.busLost) nextState = ST_DEEP;
        else if (!sleepReq)      nextState = ST_STOPGRANT;
      end
      ST_DEEP: begin
        if (status.settleDone) nextState = ST_SLEEP;
      end
      default: nextState = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_NORMAL;
      origin   <= ST_NORMAL;
      snoopRet <= ST_AUTOHALT;
      flushAck <= 1'b0;
    end else begin
      state    <= nextState;
      origin   <= originNext;
      snoopRet <= snoopRetNext;
      flushAck <= flushNext;
    end
  end

  assign strobe.latchEn = (state == ST_STOPGRANT);
  assign strobe.clrPend = (state == ST_NORMAL) ||
                          (cpuReset && (state == ST_STOPGRANT || state == ST_SLEEP));
  assign strobe.sleepy  = (state == ST_SLEEP) || (state == ST_DEEP);
  assign strobe.inDeep  = (state == ST_DEEP);

  assign coreClkEn  = !(state == ST_STOPGRANT || state == ST_SLEEP || state == ST_DEEP);
  assign cacheClkEn = (state != ST_DEEP);
  assign snoopAck   = (state == ST_SNOOP);

  // R2: halt in Normal enters AutoHALT
  a_r2_halt_enter: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NORMAL && !cpuReset && !stopClkReq && haltEvt) |=> state == ST_AUTOHALT);

  // R3: flush pulse only follows AutoHALT
  a_r3_flush_src: assert property (@(posedge clk) disable iff (!rstN)
    flushAck |-> $past(state) == ST_AUTOHALT);

  // R6: a finished snoop returns to a halted or stop-grant state
  a_r6_snoop_return: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SNOOP && !snoopReq) |=> (state == ST_AUTOHALT || state == ST_STOPGRANT));

  // R7: Sleep is reached only from Stop-Grant or Deep Sleep
  a_r7_sleep_source: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP && $past(state) != ST_SLEEP) |->
      ($past(state) == ST_STOPGRANT || $past(state) == ST_DEEP));

  // R8: Deep Sleep is left only towards Sleep
  a_r8_deep_exit: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_DEEP && state != ST_DEEP) |-> state == ST_SLEEP);

endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
  import pwr_pkg::*;
#(
  parameter int LOSS_CYC   = 16,
  parameter int SETTLE_CYC = 100000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busClkIn,
  input  logic       haltEvt,
  input  logic       stopClkReq,
  input  logic       sleepReq,
  input  logic       snoopReq,
  input  logic       smiIn,
  input  logic       initIn,
  input  logic       nmiIn,
  input  logic       intrIn,
  input  logic       flushReq,
  input  logic       cpuReset,
  output logic [2:0] stateCode,
  output logic       coreClkEn,
  output logic       cacheClkEn,
  output logic       snoopAck,
  output logic       flushAck,
  output logic [3:0] pendIrq,
  output logic       protoErr
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;
  pwrState_e   state;

  pwr_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .haltEvt    (haltEvt),
    .stopClkReq (stopClkReq),
    .sleepReq   (sleepReq),
    .snoopReq   (snoopReq),
    .flushReq   (flushReq),
    .cpuReset   (cpuReset),
    .status     (status),
    .state      (state),
    .strobe     (strobe),
    .flushAck   (flushAck),
    .coreClkEn  (coreClkEn),
    .cacheClkEn (cacheClkEn),
    .snoopAck   (snoopAck)
  );

  pwr_dp #(
    .LOSS_CYC   (LOSS_CYC),
    .SETTLE_CYC (SETTLE_CYC)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .busClkIn (busClkIn),
    .irqIn    ({smiIn, initIn, nmiIn, intrIn}),
    .snoopReq (snoopReq),
    .sleepReq (sleepReq),
    .strobe   (strobe),
    .status   (status),
    .pendIrq  (pendIrq),
    .protoErr (protoErr)
  );

  assign stateCode = state;

endmodule

// File: tb/test_pwr_state_ctl.sv
module test_pwr_state_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int LOSS       = 16;
  localparam int SETTLE     = 40;

  logic clk = 0;
  logic rstN = 0;
  logic busClkIn = 0, busRun = 1;
  logic haltEvt = 0, stopClkReq = 0, sleepReq = 0, snoopReq = 0;
  logic smiIn = 0, initIn = 0, nmiIn = 0, intrIn = 0;
  logic flushReq = 0, cpuReset = 0;
  logic [2:0] stateCode;
  logic coreClkEn, cacheClkEn, snoopAck, flushAck, protoErr;
  logic [3:0] pendIrq;

  int checks = 0, failures = 0;
  bit finished = 0;

  typedef struct {
    string      tag;
    logic [2:0] st;
    logic [3:0] pend;
    logic       err;
    logic       flush;
  } expItem_t;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_state_ctl #(.LOSS_CYC(LOSS), .SETTLE_CYC(SETTLE)) i_pwr_state_ctl (
    .clk(clk), .rstN(rstN), .busClkIn(busClkIn), .haltEvt(haltEvt),
    .stopClkReq(stopClkReq), .sleepReq(sleepReq), .snoopReq(snoopReq),
    .smiIn(smiIn), .initIn(initIn), .nmiIn(nmiIn), .intrIn(intrIn),
    .flushReq(flushReq), .cpuReset(cpuReset), .stateCode(stateCode),
    .coreClkEn(coreClkEn), .cacheClkEn(cacheClkEn), .snoopAck(snoopAck),
    .flushAck(flushAck), .pendIrq(pendIrq), .protoErr(protoErr));

  // bus clock: toggles every 4 reference cycles while running
  initial forever begin
    repeat (4) @(posedge clk);
    #1;
    if (busRun) busClkIn = ~busClkIn;
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string tag, input logic [2:0] st,
                            input logic [3:0] pend, input logic err, input logic flush);
    expItem_t it;
    it.tag = tag; it.st = st; it.pend = pend; it.err = err; it.flush = flush;
    expQ.push_back(it);
  endtask

  task automatic wait_state(input logic [2:0] code, input int maxCyc);
    for (int i = 0; i < maxCyc && stateCode != code; i++) step(1);
  endtask

  // monitor: compares every queued expectation on the falling edge
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      expItem_t it;
      logic expCore, expCache, expAck;
      it = expQ.pop_front();
      expCore  = !(it.st == 3'd3 || it.st == 3'd5 || it.st == 3'd6);
      expCache = (it.st != 3'd6);
      expAck   = (it.st == 3'd4);
      checks++;
      if (stateCode !== it.st || pendIrq !== it.pend || protoErr !== it.err ||
          flushAck !== it.flush || coreClkEn !== expCore ||
          cacheClkEn !== expCache || snoopAck !== expAck) begin
        failures++;
        $display("FAIL %s: got st=%0d pend=%b err=%b flush=%b core=%b cache=%b ack=%b exp st=%0d pend=%b err=%b flush=%b core=%b cache=%b ack=%b",
                 it.tag, stateCode, pendIrq, protoErr, flushAck, coreClkEn, cacheClkEn, snoopAck,
                 it.st, it.pend, it.err, it.flush, expCore, expCache, expAck);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got running exp done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1;
    step(1);
    expect_out("R1 reset state", 3'd1, 4'b0000, 0, 0);

    // R2 halt entry
    haltEvt = 1; step(1); haltEvt = 0;
    expect_out("R2 halt enters AutoHALT", 3'd2, 4'b0000, 0, 0);

    // R3 flush serviced in AutoHALT
    flushReq = 1; step(1); flushReq = 0;
    expect_out("R3 flush pulse in AutoHALT", 3'd2, 4'b0000, 0, 1);
    step(1);
    expect_out("R3 flush pulse ends", 3'd2, 4'b0000, 0, 0);

    // R4 stop-clock from AutoHALT, R10 core clock off
    stopClkReq = 1; step(1);
    expect_out("R4 R10 Stop-Grant from AutoHALT", 3'd3, 4'b0000, 0, 0);

    // R5 latching
    smiIn = 1; step(1); smiIn = 0; step(1);
    expect_out("R5 SMI latched", 3'd3, 4'b1000, 0, 0);
    smiIn = 1; nmiIn = 1; step(1); smiIn = 0; nmiIn = 0; step(1);
    expect_out("R5 repeat SMI held once plus NMI", 3'd3, 4'b1010, 0, 0);

    // R3 flush ignored in Stop-Grant
    flushReq = 1; step(1); flushReq = 0;
    expect_out("R3 flush ignored in Stop-Grant", 3'd3, 4'b1010, 0, 0);

    // R6 snoop from Stop-Grant
    snoopReq = 1; step(1);
    expect_out("R6 snoop from Stop-Grant", 3'd4, 4'b1010, 0, 0);
    snoopReq = 0; step(1);
    expect_out("R6 snoop returns to Stop-Grant", 3'd3, 4'b1010, 0, 0);

    // R4 return to origin, R5 delivery
    stopClkReq = 0; step(1);
    expect_out("R4 release returns to AutoHALT", 3'd2, 4'b1010, 0, 0);
    step(1);
    expect_out("R5 held interrupt wakes to Normal", 3'd1, 4'b1010, 0, 0);
    step(1);
    expect_out("R5 held interrupts cleared after Normal", 3'd1, 4'b0000, 0, 0);

    // R7 sleep ignored in Normal and AutoHALT
    sleepReq = 1; step(12);
    expect_out("R7 sleep ignored in Normal", 3'd1, 4'b0000, 0, 0);
    haltEvt = 1; step(1); haltEvt = 0; step(12);
    expect_out("R7 sleep ignored in AutoHALT", 3'd2, 4'b0000, 0, 0);
    sleepReq = 0;
    intrIn = 1; step(1); intrIn = 0;
    expect_out("R2 interrupt wakes AutoHALT", 3'd1, 4'b0000, 0, 0);
    step(1);

    // R7 sleep from Stop-Grant after qualification
    stopClkReq = 1; step(1);
    sleepReq = 1; step(1);
    expect_out("R7 sleep not taken at once", 3'd3, 4'b0000, 0, 0);
    wait_state(3'd5, 60);
    expect_out("R7 R10 sleep entered", 3'd5, 4'b0000, 0, 0);

    // R11 protocol error in Sleep
    intrIn = 1; step(1);
    expect_out("R11 interrupt change in Sleep", 3'd5, 4'b0000, 1, 0);
    step(1);
    expect_out("R11 error is one cycle", 3'd5, 4'b0000, 0, 0);
    intrIn = 0; step(2);

    // R8 bus clock loss
    busRun = 0; step(2);
    expect_out("R8 not deep immediately", 3'd5, 4'b0000, 0, 0);
    wait_state(3'd6, 60);
    expect_out("R8 R10 deep sleep on bus loss", 3'd6, 4'b0000, 0, 0);
    snoopReq = 1; step(1);
    expect_out("R11 snoop change in Deep Sleep", 3'd6, 4'b0000, 1, 0);
    snoopReq = 0; step(2);

    // R8 settle interval
    busRun = 1; step(20);
    expect_out("R8 still deep during settle", 3'd6, 4'b0000, 0, 0);
    wait_state(3'd5, SETTLE + 60);
    expect_out("R8 back to Sleep after settle", 3'd5, 4'b0000, 0, 0);
    sleepReq = 0; step(1);
    expect_out("R8 sleep release to Stop-Grant", 3'd3, 4'b0000, 0, 0);

    // R9 reset in Stop-Grant
    initIn = 1; step(1); initIn = 0; step(1);
    expect_out("R5 INIT latched", 3'd3, 4'b0100, 0, 0);
    cpuReset = 1; step(1); cpuReset = 0;
    expect_out("R9 reset keeps Stop-Grant and clears", 3'd3, 4'b0000, 0, 0);

    // R9 reset in Sleep
    sleepReq = 1;
    wait_state(3'd5, 60);
    expect_out("R7 sleep entered again", 3'd5, 4'b0000, 0, 0);
    cpuReset = 1; stopClkReq = 0; sleepReq = 0; step(1); cpuReset = 0;
    expect_out("R9 reset in Sleep goes to Normal", 3'd1, 4'b0000, 0, 0);

    // R6 snoop from AutoHALT
    haltEvt = 1; step(1); haltEvt = 0;
    snoopReq = 1; step(1);
    expect_out("R6 snoop from AutoHALT", 3'd4, 4'b0000, 0, 0);
    snoopReq = 0; step(1);
    expect_out("R6 snoop returns to AutoHALT", 3'd2, 4'b0000, 0, 0);
    nmiIn = 1; step(1); nmiIn = 0;
    expect_out("R2 NMI wakes AutoHALT", 3'd1, 4'b0000, 0, 0);

    // R4 origin Normal
    stopClkReq = 1; step(1);
    expect_out("R4 Stop-Grant from Normal", 3'd3, 4'b0000, 0, 0);
    stopClkReq = 0; step(1);
    expect_out("R4 release returns to Normal", 3'd1, 4'b0000, 0, 0);

    step(2);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule